// File: doc/BRIEF.md
# Downspread Modulation Profile Generator

This block produces the digital modulation profile that a fractional clock synthesizer adds to its feedback divider. Sweeping the output frequency slowly below nominal spreads the clock energy over a band and lowers peak emissions. The profile is a symmetric triangle that starts at zero and falls to a programmed negative depth. It then climbs back to zero and repeats. The offset is never positive, so the synthesized clock never runs faster than nominal.

Spreading is requested by pulling the active-low `ss_req_n` pin low. It is honoured only while the rate-select code names one of the two real operating frequencies. For test, tri-state and reserved codes the request pin has no effect. The depth is sampled once, when a sweep begins. When the request goes away, the profile keeps climbing at its normal step rate until it reaches zero. Only then does the `spreading` flag drop, so the frequency never jumps.

With the default parameters the ramp has 16 steps each way and a step lasts 14 reference cycles. One full triangle therefore takes 448 cycles, which is about 31.96 kHz from a 14.318 MHz reference.

Top module: `dss_modulator`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `offset` is 0 and `spreading` is 0.
- R2: The code `rate_sel` is read as {high-rate bit, bit1, bit0}, and only the codes 3'b011 and 3'b111 allow spreading. With such a code and `ss_req_n` low at a rising edge, `spreading` rises two rising edges later. It is 0 after the first of those two edges.
- R3: With any other `rate_sel` code (3'b000, 3'b001, 3'b010, 3'b100, 3'b101, 3'b110), a low `ss_req_n` has no effect: `spreading` stays 0 and `offset` stays 0.
- R4: `offset` is never positive. Its magnitude never exceeds the depth captured at the start of the sweep.
- R5: The step index k rises by one every 14 cycles, from 0 up to 16, then falls by one every 14 cycles back to 0, and repeats. The first step comes 14 cycles after `spreading` rises. At each step `offset` equals -floor(depth*k/16).
- R6: One full triangle, from one arrival at the deepest point to the next, lasts 448 cycles, which places the modulation rate inside 30 to 33 kHz for a 14.318 MHz reference.
- R7: `depth` is captured on the edge where `spreading` rises. Changing it during a sweep has no effect on `offset` until the next sweep starts.
- R8: After the request is withdrawn, `offset` only moves toward zero, at the normal step rate. `spreading` falls one cycle after `offset` reaches 0.
- R9: If the request returns while the profile is still climbing back after a withdrawal, `spreading` stays 1. If the sweep was heading downward before the withdrawal, it resumes heading downward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ss_req_n | input | 1 | Active-low spread request |
| rate_sel | input | 3 | Output frequency select code |
| depth | input | DEPTH_W (8) | Deepest offset magnitude, in divider LSBs |
| offset | output | DEPTH_W+1 (9) | Signed offset word for the feedback divider |
| spreading | output | 1 | High while a modulation sweep is in progress |

## Verification
The request pin and the code are registered once, so `spreading` answers a request on the second rising edge. `offset` is registered straight from the next step index, so it changes on the same edge as the step counter, 14 edges after `spreading` rises and every 14 edges after that. The bench drives inputs just after a falling edge and samples at the falling edge that follows the counted number of rising edges. A cycle-level model, advanced on each rising edge from the requirements, supplies the expected value for every cycle of both the directed and the random phases.

// File: rtl/dss_pkg.sv
package dss_pkg;

  typedef enum logic {
    SWEEP_UP   = 1'b0,  // step index falling, frequency returning to nominal
    SWEEP_DOWN = 1'b1   // step index rising, frequency moving below nominal
  } sweep_dir_e;

  // Only the two real operating codes may spread: low bits both set.
  function automatic logic is_spread_code(input logic [2:0] code);
    return code[1] & code[0];
  endfunction

endpackage

// File: rtl/dss_tick_gen.sv
module dss_tick_gen #(
  parameter int TICK_DIV = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dss_ramp.sv
module dss_ramp
  import dss_pkg::*;
#(
  parameter int STEPS_LOG2 = 4,
  localparam int POS_W = STEPS_LOG2 + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             want_down,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] pos_nxt
);
  localparam logic [POS_W-1:0] TOP = POS_W'(1 << STEPS_LOG2);

  sweep_dir_e dir, dir_nxt;

  always_comb begin
    pos_nxt = pos;
    dir_nxt = dir;
    if (!run) begin
      pos_nxt = '0;
      dir_nxt = SWEEP_DOWN;
    end else if (tick) begin
      if (dir == SWEEP_DOWN && want_down) begin
        pos_nxt = pos + 1'b1;
        if (pos_nxt == TOP) dir_nxt = SWEEP_UP;
      end else if (pos != '0) begin
        pos_nxt = pos - 1'b1;
        if (pos_nxt == '0) dir_nxt = SWEEP_DOWN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      dir <= SWEEP_DOWN;
    end else begin
      pos <= pos_nxt;
      dir <= dir_nxt;
    end
  end
endmodule

// File: rtl/dss_scale.sv
module dss_scale #(
  parameter int DEPTH_W    = 8,
  parameter int STEPS_LOG2 = 4,
  localparam int POS_W  = STEPS_LOG2 + 1,
  localparam int PROD_W = DEPTH_W + POS_W,
  localparam int OFS_W  = DEPTH_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DEPTH_W-1:0]      depth,
  input  logic [POS_W-1:0]        pos,
  output logic signed [OFS_W-1:0] offset
);
  logic [PROD_W-1:0]  prod;
  logic [DEPTH_W-1:0] mag;

  assign prod = {{POS_W{1'b0}}, depth} * {{DEPTH_W{1'b0}}, pos};
  assign mag  = prod[STEPS_LOG2 +: DEPTH_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      offset <= '0;
    end else begin
      offset <= -$signed({1'b0, mag});
    end
  end
endmodule

// File: rtl/dss_modulator.sv
module dss_modulator
  import dss_pkg::*;
#(
  parameter int DEPTH_W    = 8,
  parameter int STEPS_LOG2 = 4,
  parameter int TICK_DIV   = 14,
  localparam int POS_W = STEPS_LOG2 + 1,
  localparam int OFS_W = DEPTH_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ss_req_n,
  input  logic [2:0]              rate_sel,
  input  logic [DEPTH_W-1:0]      depth,
  output logic signed [OFS_W-1:0] offset,
  output logic                    spreading
);
  logic               en_q;
  logic [DEPTH_W-1:0] depth_q;
  logic               start, stop, run, tick;
  logic [POS_W-1:0]   pos, pos_nxt;

  assign start = !spreading && en_q;
  assign stop  = spreading && !en_q && (pos == '0);
  assign run   = spreading && !stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      spreading <= 1'b0;
      depth_q   <= '0;
    end else begin
      en_q <= !ss_req_n && is_spread_code(rate_sel);
      if (start) begin
        spreading <= 1'b1;
        depth_q   <= depth;
      end else if (stop) begin
        spreading <= 1'b0;
      end
    end
  end

  dss_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick)
  );

  dss_ramp #(.STEPS_LOG2(STEPS_LOG2)) u_ramp (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .tick     (tick),
    .want_down(en_q),
    .pos      (pos),
    .pos_nxt  (pos_nxt)
  );

  dss_scale #(.DEPTH_W(DEPTH_W), .STEPS_LOG2(STEPS_LOG2)) u_scale (
    .clk   (clk),
    .rst   (rst),
    .depth (depth_q),
    .pos   (pos_nxt),
    .offset(offset)
  );
endmodule

// File: rtl/dss_modulator_chk.sv
module dss_modulator_chk
  import dss_pkg::*;
#(
  parameter int DEPTH_W = 8,
  localparam int OFS_W = DEPTH_W + 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ss_req_n,
  input logic [2:0]              rate_sel,
  input logic [DEPTH_W-1:0]      depth_q,
  input logic signed [OFS_W-1:0] offset,
  input logic                    spreading
);
  logic                    req_ok;
  logic signed [OFS_W:0]   headroom;

  assign req_ok   = !ss_req_n && is_spread_code(rate_sel);
  assign headroom = $signed({2'b00, depth_q}) + OFS_W'(offset);

  AST_NEVER_ABOVE_NOMINAL: assert property (@(posedge clk) disable iff (rst)
    offset <= 0);  // R4

  AST_WITHIN_DEPTH: assert property (@(posedge clk) disable iff (rst)
    headroom >= 0);  // R4

  AST_START_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (rst)
    $rose(spreading) |-> $past(req_ok, 2));  // R2

  AST_IDLE_AT_NOMINAL: assert property (@(posedge clk) disable iff (rst)
    !spreading |-> offset == 0);  // R3

  AST_EXIT_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(spreading) |-> ($past(offset) == 0));  // R8
endmodule

bind dss_modulator dss_modulator_chk #(.DEPTH_W(DEPTH_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ss_req_n (ss_req_n),
  .rate_sel (rate_sel),
  .depth_q  (depth_q),
  .offset   (offset),
  .spreading(spreading)
);

// File: tb/tb_dss_modulator.sv
module tb_dss_modulator;
  localparam int CLK_PERIOD = 70;
  localparam int DW   = 8;
  localparam int TD   = 14;
  localparam int TOPK = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ss_req_n = 1'b1;
  logic [2:0] rate_sel = 3'b011;
  logic [DW-1:0] depth = '0;
  logic signed [DW:0] offset;
  logic spreading;

  int checks = 0;
  int errs   = 0;
  bit mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dss_modulator dut (
    .clk(clk), .rst(rst), .ss_req_n(ss_req_n), .rate_sel(rate_sel),
    .depth(depth), .offset(offset), .spreading(spreading)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit spread_code(input logic [2:0] c);
    return (c == 3'b011) || (c == 3'b111);
  endfunction

  function automatic int exp_offset(input int dep, input int k);
    return -((dep * k) / TOPK);
  endfunction

  // Reference model of the requirements, advanced on each rising edge.
  bit m_enq, m_act, m_down;
  int m_tc, m_k, m_dep;
  always @(posedge clk) begin
    if (rst) begin
      m_enq <= 0; m_act <= 0; m_down <= 1; m_tc <= 0; m_k <= 0; m_dep <= 0;
    end else begin
      m_enq <= !ss_req_n && spread_code(rate_sel);
      if (!m_act) begin
        if (m_enq) begin m_act <= 1; m_dep <= int'(depth); end
        m_tc <= 0; m_k <= 0; m_down <= 1;
      end else if (!m_enq && m_k == 0) begin
        m_act <= 0; m_tc <= 0; m_down <= 1;
      end else if (m_tc == TD-1) begin
        m_tc <= 0;
        if (m_down && m_enq) begin
          m_k <= m_k + 1;
          if (m_k + 1 == TOPK) m_down <= 0;
        end else if (m_k != 0) begin
          m_k <= m_k - 1;
          if (m_k == 1) m_down <= 1;
        end
      end else begin
        m_tc <= m_tc + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (mon_on && !rst) begin
      chk(int'(offset) == exp_offset(m_dep, m_k), "R5 model offset", int'(offset), exp_offset(m_dep, m_k));
      chk(spreading == m_act, "R2 model spreading", int'(spreading), int'(m_act));
      chk(offset <= 0 && -int'(offset) <= m_dep, "R4 bound", int'(offset), -m_dep);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int prev;
    int hit0;
    void'($urandom(32'h5EED));
    cyc(4);
    chk(offset == 0 && spreading == 0, "R1 in reset", int'(offset), 0);
    rst = 1'b0;
    cyc(1);
    chk(offset == 0 && spreading == 0, "R1 after reset", int'(spreading), 0);
    mon_on = 1'b1;

    // R2: start latency with a valid code
    depth = 8'd160; rate_sel = 3'b011;
    cyc(5);
    chk(spreading == 0, "R2 idle while not requested", int'(spreading), 0);
    ss_req_n = 1'b0;
    cyc(1);
    chk(spreading == 0, "R2 one edge after request", int'(spreading), 0);
    cyc(1);
    chk(spreading == 1, "R2 two edges after request", int'(spreading), 1);
    cyc(13);
    chk(offset == 0, "R5 before first step", int'(offset), 0);
    cyc(1);
    chk(int'(offset) == -10, "R5 first step", int'(offset), -10);
    depth = 8'd40;  // R7: must be ignored during this sweep
    cyc(210);
    chk(int'(offset) == -160, "R7 depth held at deepest point", int'(offset), -160);
    cyc(447);
    chk(int'(offset) == -150, "R6 one step before next deepest", int'(offset), -150);
    cyc(1);
    chk(int'(offset) == -160, "R6 deepest again after 448 cycles", int'(offset), -160);

    // R8: withdraw and watch the return
    ss_req_n = 1'b1;
    prev = int'(offset);
    hit0 = 0;
    for (int i = 0; i < 600 && spreading; i++) begin
      cyc(1);
      chk(int'(offset) >= prev, "R8 monotonic return", int'(offset), prev);
      if (hit0 == 1) chk(spreading == 0, "R8 flag drops one cycle after zero", int'(spreading), 0);
      else if (offset == 0) begin
        chk(spreading == 1, "R8 flag still high at zero", int'(spreading), 1);
        hit0 = 1;
      end
      prev = int'(offset);
    end
    chk(spreading == 0 && hit0 == 1, "R8 return completed", int'(spreading), 0);

    // R3: invalid codes ignore the request
    for (int c = 0; c < 8; c++) begin
      if (spread_code(3'(c))) continue;
      rate_sel = 3'(c); ss_req_n = 1'b0;
      cyc(40);
      chk(spreading == 0 && offset == 0, "R3 request ignored", int'(spreading), 0);
      ss_req_n = 1'b1;
      cyc(3);
    end

    // R9: withdraw during the descent, then request again
    rate_sel = 3'b111; depth = 8'd64; ss_req_n = 1'b0;
    cyc(2 + TD*5);
    ss_req_n = 1'b1;
    cyc(TD*2);
    prev = int'(offset);
    chk(prev < 0, "R9 still below nominal", prev, -1);
    ss_req_n = 1'b0;
    for (int i = 0; i < 60; i++) begin
      cyc(1);
      if (!spreading) chk(0, "R9 flag held", 0, 1);
    end
    chk(int'(offset) < prev, "R9 resumed downward", int'(offset), prev - 1);
    ss_req_n = 1'b1;
    cyc(TD*20);
    chk(spreading == 0, "R8 stop after sweep", int'(spreading), 0);

    // Random phase checked against the model
    for (int i = 0; i < 5000; i++) begin
      if ($urandom % 150 == 0) ss_req_n = ~ss_req_n;
      if ($urandom % 400 == 0) rate_sel = ($urandom % 2) ? 3'b011 + 3'(($urandom % 2) * 4) : 3'($urandom);
      if ($urandom % 97 == 0) depth = DW'($urandom);
      cyc(1);
    end
    mon_on = 1'b0;
    finish_run();
  end
endmodule